// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block holds the control state for one 128-position digital potentiometer. A host reaches it through a byte-wide register bus: a two-bit address, a write strobe, a read strobe, write data and registered read data. The block drives a 7-bit wiper code, a shutdown flag and a voltage-divider mode flag to the analog array. The serial protocol and the resistor array are outside the block.

The stored wiper value and the mode register are non-volatile in intent. Here they are flip-flops that take their factory values at reset. Any write to them starts a timed write cycle, and while that cycle runs every register write is refused. Address 0 is shared between the live wiper and the stored wiper value. A steering bit in the control register picks which of the two it reaches.

Two state machines govern the block. The boot machine has the states BOOT_WAIT, BOOT_RECALL and BOOT_RUN:
- From BOOT_WAIT it moves to BOOT_RECALL once power-good has been high for SETTLE_CYC consecutive clocks.
- BOOT_RECALL copies the stored value into the wiper in one clock and then moves to BOOT_RUN.
- A low power-good in any state sends the machine back to BOOT_WAIT.

The write-cycle timer has the states NV_IDLE and NV_BUSY:
- A start pulse moves it from NV_IDLE to NV_BUSY.
- It returns to NV_IDLE after NVW_CYC clocks.

Top module: `potctl_top`

## Requirements
- R1: `wiper_code` always equals the live wiper register. With the steering bit (control bit 7) at 1, a read of address 0 returns `{1'b0, wiper}`. Code 00h is the low end of the wiper range and 7Fh is the high end.
- R2: After reset, the block is in the following state:
  - the wiper is 40h and the stored value is 40h;
  - the steering bit is 0 and control bit 6 is 1, so `pot_shutdown` is 0;
  - the mode register is 00h, so `div_mode` is 0.
- R3: The wiper holds 40h until `pwr_good` has been high for SETTLE_CYC consecutive clocks. One clock later, the stored value's low 7 bits are loaded into the wiper. A low `pwr_good` forces the wiper to 40h, sets the steering bit to 0 and sets control bit 6 to 1.
- R4: With the steering bit at 0, a write to address 0 updates both the stored value (8 bits) and the wiper (low 7 bits), and starts a write cycle. A read of address 0 then returns the stored value.
- R5: With the steering bit at 1, a write to address 0 changes only the wiper. It leaves the stored value unchanged and starts no write cycle.
- R6: The mode register is at address 1. A write stores bits 7 and 6 and starts a write cycle. Reads return the low six bits as 0. Bit 7 drives `div_mode`.
- R7: The control register is at address 2. Bit 7 is the steering bit and bit 6 is an active-low shutdown bit (`pot_shutdown` is 1 when the bit is 0). A read returns `{steer, shdn_n, busy, 5'b0}`, and writes to bits 5..0 have no effect.
- R8: The busy bit (address 2, bit 5) is 1 for NVW_CYC clocks after a write cycle starts, and 0 after that.
- R9: While busy is 1, writes to addresses 0, 1 and 2 are ignored.
- R10: Writes made before BOOT_RUN are ignored. A write to address 3 changes nothing, and a read of address 3 returns 00h.
- R11: `bus_rdata` is updated only at a clock edge where `bus_rd` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads factory values |
| pwr_good | input | 1 | Supply valid indication |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wiper_code | output | 7 | Wiper position code |
| pot_shutdown | output | 1 | High when the potentiometer is in shutdown |
| div_mode | output | 1 | High for voltage-divider mode, low for rheostat |

## Verification
The assertions assume three things about the inputs:
- A write strobe lasts one clock.
- `pwr_good` and the bus inputs change only between clock edges.
- `rst_n` is asserted once at the start.

The wiper-hold check after a refused write, and the recall check, only hold while `pwr_good` is high, so both properties include `pwr_good` in their antecedents. The bench drives every input on the falling edge and pulses each strobe for one clock. It lowers `pwr_good` only between bus transactions, so a power drop never coincides with a write.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
    localparam int CODE_W = 7;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_WIPER = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd2;

    localparam logic [CODE_W-1:0] MID_CODE    = 7'h40;
    localparam logic [DATA_W-1:0] FACTORY_IVR = 8'h40;

    typedef enum logic [1:0] {
        BOOT_WAIT   = 2'd0,
        BOOT_RECALL = 2'd1,
        BOOT_RUN    = 2'd2
    } boot_state_t;

    typedef enum logic {
        NV_IDLE = 1'b0,
        NV_BUSY = 1'b1
    } nv_state_t;

    typedef struct packed {
        logic steer;
        logic shdn_n;
    } ctrl_t;
endpackage

// File: rtl/potctl_boot.sv
module potctl_boot
    import potctl_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic in_wait,
    output logic do_recall,
    output logic in_run
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    boot_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BOOT_WAIT:   if (pwr_good && cnt_q == LAST) state_d = BOOT_RECALL;
            BOOT_RECALL: state_d = pwr_good ? BOOT_RUN : BOOT_WAIT;
            BOOT_RUN:    if (!pwr_good) state_d = BOOT_WAIT;
            default:     state_d = BOOT_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BOOT_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BOOT_WAIT && pwr_good && cnt_q != LAST)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    always_comb begin
        in_wait   = (state_q == BOOT_WAIT);
        do_recall = (state_q == BOOT_RECALL);
        in_run    = (state_q == BOOT_RUN);
    end

    // R3
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BOOT_WAIT && !pwr_good) |=> state_q == BOOT_WAIT);

    // R3
    recall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BOOT_RECALL) |=> state_q != BOOT_RECALL);
endmodule

// File: rtl/potctl_nvtimer.sv
module potctl_nvtimer
    import potctl_pkg::*;
#(
    parameter int NVW_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(NVW_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(NVW_CYC - 1);

    nv_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NV_IDLE: if (start) state_d = NV_BUSY;
            NV_BUSY: if (cnt_q == LAST) state_d = NV_IDLE;
            default: state_d = NV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == NV_BUSY && cnt_q != LAST)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    always_comb begin
        busy = (state_q == NV_BUSY);
    end

    // R8
    nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/potctl_regfile.sv
module potctl_regfile
    import potctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              in_run,
    input  logic              in_wait,
    input  logic              do_recall,
    input  logic              nv_busy,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nv_start,
    output logic [CODE_W-1:0] wiper,
    output logic              shdn_n,
    output logic              div_sel
);
    logic [CODE_W-1:0] wiper_q;
    logic [DATA_W-1:0] ivr_q;
    logic [1:0]        msr_q;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    logic wr_ok, hit_wiper, hit_ivr, hit_mode, hit_ctrl;

    always_comb begin
        wr_ok     = in_run && bus_wr && pwr_good && !nv_busy;
        hit_wiper = wr_ok && bus_addr == ADR_WIPER && ctrl_q.steer;
        hit_ivr   = wr_ok && bus_addr == ADR_WIPER && !ctrl_q.steer;
        hit_mode  = wr_ok && bus_addr == ADR_MODE;
        hit_ctrl  = wr_ok && bus_addr == ADR_CTRL;
        nv_start  = hit_ivr || hit_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wiper_q <= MID_CODE;
        else if (!pwr_good)
            wiper_q <= MID_CODE;
        else if (do_recall)
            wiper_q <= ivr_q[CODE_W-1:0];
        else if (hit_wiper || hit_ivr)
            wiper_q <= bus_wdata[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ivr_q <= FACTORY_IVR;
        else if (hit_ivr)
            ivr_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            msr_q <= '0;
        else if (hit_mode)
            msr_q <= bus_wdata[7:6];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '{steer: 1'b0, shdn_n: 1'b1};
        else if (!pwr_good)
            ctrl_q <= '{steer: 1'b0, shdn_n: 1'b1};
        else if (hit_ctrl)
            ctrl_q <= '{steer: bus_wdata[7], shdn_n: bus_wdata[6]};
    end

    always_comb begin
        unique case (bus_addr)
            ADR_WIPER: rd_mux = ctrl_q.steer ? {1'b0, wiper_q} : ivr_q;
            ADR_MODE:  rd_mux = {msr_q, 6'b0};
            ADR_CTRL:  rd_mux = {ctrl_q.steer, ctrl_q.shdn_n, nv_busy, 5'b0};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_mux;
    end

    always_comb begin
        bus_rdata = rdata_q;
        wiper     = wiper_q;
        shdn_n    = ctrl_q.shdn_n;
        div_sel   = msr_q[1];
    end

    // R3
    boot_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> wiper_q == MID_CODE);

    // R3
    recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_recall && pwr_good) |=> wiper_q == $past(ivr_q[CODE_W-1:0]));

    // R9
    wip_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && nv_busy && pwr_good && !do_recall) |=>
            ($stable(wiper_q) && $stable(ivr_q) && $stable(msr_q) && $stable(ctrl_q)));

    // R9
    nv_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_start |-> !nv_busy);

    // R7
    ctrl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_CTRL) |=> bus_rdata[4:0] == 5'b0);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/potctl_top.sv
module potctl_top
    import potctl_pkg::*;
#(
    parameter int SETTLE_CYC = 16,
    parameter int NVW_CYC    = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [6:0] wiper_code,
    output logic       pot_shutdown,
    output logic       div_mode
);
    logic in_wait, do_recall, in_run;
    logic nv_start, nv_busy;
    logic shdn_n;

    potctl_boot #(.SETTLE_CYC(SETTLE_CYC)) u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .in_wait   (in_wait),
        .do_recall (do_recall),
        .in_run    (in_run)
    );

    potctl_nvtimer #(.NVW_CYC(NVW_CYC)) u_nvt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (nv_busy)
    );

    potctl_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .in_run    (in_run),
        .in_wait   (in_wait),
        .do_recall (do_recall),
        .nv_busy   (nv_busy),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .nv_start  (nv_start),
        .wiper     (wiper_code),
        .shdn_n    (shdn_n),
        .div_sel   (div_mode)
    );

    always_comb pot_shutdown = ~shdn_n;

    // R7
    shdn_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !pot_shutdown);
endmodule

// File: tb/sim_potctl_top.sv
module sim_potctl_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;
    localparam int NVW        = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] wiper_code;
    logic       pot_shutdown;
    logic       div_mode;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    potctl_top #(.SETTLE_CYC(SETTLE), .NVW_CYC(NVW)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wiper_code(wiper_code), .pot_shutdown(pot_shutdown), .div_mode(div_mode)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_nv();
        repeat (NVW + 4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R2 wiper", {1'b0, wiper_code}, 8'h40);
        check("R2 shutdown", {7'b0, pot_shutdown}, 8'h00);
        check("R2 mode", {7'b0, div_mode}, 8'h00);
        bus_read(2'd2, rv); check("R2 ctrl", rv, 8'h40);
        bus_read(2'd0, rv); check("R2 stored", rv, 8'h40);
        bus_read(2'd1, rv); check("R2 msr", rv, 8'h00);
    endtask

    task automatic t_early_write();
        bus_write(2'd2, 8'h00);
        check("R10 early ctrl", {7'b0, pot_shutdown}, 8'h00);
        bus_write(2'd0, 8'h05);
        check("R10 early wiper", {1'b0, wiper_code}, 8'h40);
    endtask

    task automatic t_powerup();
        @(negedge clk); pwr_good = 1'b1;
        repeat (SETTLE - 2) @(posedge clk);
        @(negedge clk); pwr_good = 1'b0;
        @(negedge clk); pwr_good = 1'b1;
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
        check("R3 hold before recall", {1'b0, wiper_code}, 8'h40);
        @(negedge clk);
        bus_write(2'd2, 8'hC0);
        bus_read(2'd2, rv); check("R3 run reached", rv, 8'hC0);
    endtask

    task automatic t_volatile();
        bus_write(2'd0, 8'h7F);
        check("R1 high end", {1'b0, wiper_code}, 8'h7F);
        bus_write(2'd0, 8'h80);
        check("R1 low end", {1'b0, wiper_code}, 8'h00);
        bus_write(2'd0, 8'h33);
        bus_read(2'd0, rv); check("R1 readback", rv, 8'h33);
        bus_read(2'd2, rv); check("R5 no busy", rv, 8'hC0);
        bus_write(2'd2, 8'h40);
        bus_read(2'd0, rv); check("R5 stored unchanged", rv, 8'h40);
    endtask

    task automatic t_shutdown();
        bus_write(2'd2, 8'h3F);
        check("R7 shutdown on", {7'b0, pot_shutdown}, 8'h01);
        bus_read(2'd2, rv); check("R7 low bits ignored", rv, 8'h00);
        bus_write(2'd2, 8'h40);
        check("R7 shutdown off", {7'b0, pot_shutdown}, 8'h00);
    endtask

    task automatic t_nv_write();
        bus_write(2'd0, 8'h95);
        check("R4 wiper follows", {1'b0, wiper_code}, 8'h15);
        bus_read(2'd2, rv); check("R8 busy set", rv, 8'h60);
        bus_write(2'd2, 8'hC0);
        bus_write(2'd0, 8'h22);
        bus_write(2'd1, 8'hC0);
        check("R9 wiper locked", {1'b0, wiper_code}, 8'h15);
        check("R9 mode locked", {7'b0, div_mode}, 8'h00);
        bus_read(2'd2, rv); check("R9 ctrl locked", rv, 8'h60);
        wait_nv();
        bus_read(2'd2, rv); check("R8 busy clear", rv, 8'h40);
        bus_read(2'd0, rv); check("R4 stored readback", rv, 8'h95);
    endtask

    task automatic t_mode();
        bus_write(2'd1, 8'hFF);
        check("R6 divider on", {7'b0, div_mode}, 8'h01);
        bus_read(2'd2, rv); check("R6 starts write cycle", rv, 8'h60);
        wait_nv();
        bus_read(2'd1, rv); check("R6 msr readback", rv, 8'hC0);
        @(negedge clk); bus_addr = 2'd2;
        repeat (3) @(negedge clk);
        check("R11 rdata held", bus_rdata, 8'hC0);
    endtask

    task automatic t_addr3();
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, rv); check("R10 addr3 reads zero", rv, 8'h00);
        bus_read(2'd2, rv); check("R10 addr3 no effect", rv, 8'h40);
    endtask

    task automatic t_recall();
        bus_write(2'd2, 8'hC0);
        bus_write(2'd0, 8'h01);
        check("R1 set before drop", {1'b0, wiper_code}, 8'h01);
        @(negedge clk); pwr_good = 1'b0;
        @(negedge clk);
        check("R3 drop to mid", {1'b0, wiper_code}, 8'h40);
        bus_read(2'd2, rv); check("R3 ctrl reset on drop", rv, 8'h40);
        @(negedge clk); pwr_good = 1'b1;
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
        check("R3 mid until recall", {1'b0, wiper_code}, 8'h40);
        @(negedge clk);
        check("R3 recall stored", {1'b0, wiper_code}, 8'h15);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_early_write();
        t_powerup();
        t_volatile();
        t_shutdown();
        t_nv_write();
        t_mode();
        t_addr3();
        t_recall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule